// File: doc/BRIEF.md
# Interrupt Request Priority Controller

This block keeps the interrupt state of a single processor: which vectors are waiting for service, which are being serviced, and whether each one was raised as a level or an edge event. A priority threshold that software writes is combined with the class of the highest vector in service to form a processor priority. A waiting vector is offered for delivery only when its class is above that priority. The class of a vector is its upper four bits.

The surrounding logic feeds the block from an accept port, one vector per cycle. It pulses an acknowledge strobe when the processor takes the offered vector. It pulses an end-of-service strobe when the handler finishes. On end-of-service the block retires the highest vector in service and reports it one cycle later, together with its trigger mode, so that a level source can re-arm. Register decoding, destination matching and timers are left to other blocks.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Vector v occupies bit v of each 256-entry bitmap, that is bit (v mod 32) of word (v div 32). `dlv_vec` shows the highest waiting vector, searched from word 7 down to word 0. It shows 0 when nothing is waiting.
- R2: `ppr` equals the stored threshold when the threshold's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise `ppr` equals that vector with its low nibble cleared. An empty in-service set counts as vector 0.
- R3: `dlv_valid` is 1 only when a vector is waiting and (`dlv_vec` AND 0xF0) is strictly greater than `ppr`.
- R4: An `ack` pulse while `dlv_valid` is 1 moves `dlv_vec` from waiting to in-service. `ppr` is updated in the next cycle. An `ack` pulse while `dlv_valid` is 0 has no effect.
- R5: An `eoi` pulse retires the highest in-service vector and clears its trigger bit. In the next cycle `eoi_valid` is 1 and `eoi_vec` is that vector. `eoi_level` is 1 if the vector was last accepted as level (`acc_level`=1) and 0 if it was accepted as edge.
- R6: An `eoi` pulse while nothing is in service changes nothing, and `eoi_valid` stays 0.
- R7: An accept with `acc_level`=1 for a vector that is already waiting is dropped. Nothing changes and `acc_new` is 0. Accepted vectors are always 16 or above.
- R8: Any other accept marks the vector waiting and records its trigger mode, overwriting any earlier mode. One cycle later `acc_new` is 1 only if the vector was not already waiting.
- R9: Accepts are ignored unless both `hw_en` and `sw_en` are 1.
- R10: A write on `thr_wr` stores only bits 7:0 of `thr_wdata`. `thr_class` shows stored bits 7:4.
- R11: Reset empties all three bitmaps and clears the threshold, so `dlv_valid`, `dlv_vec`, `ppr`, `thr_class`, `eoi_valid` and `acc_new` are 0.
- R12: When an accept and an `eoi` fall in the same cycle, the retirement is applied first and the accept second. An acknowledge in that cycle clears the waiting bit before the accept is tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable for accepts |
| sw_en | input | 1 | Software enable for accepts |
| acc_valid | input | 1 | Accept request strobe |
| acc_vec | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level trigger, 0 = edge |
| acc_new | output | 1 | Previous accept made the vector newly waiting |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 32 | Threshold write data (low 8 bits kept) |
| thr_class | output | 4 | Stored threshold bits 7:4 |
| ack | input | 1 | Processor takes the offered vector |
| eoi | input | 1 | End-of-service strobe |
| dlv_valid | output | 1 | Offered vector may be delivered |
| dlv_vec | output | 8 | Highest waiting vector |
| ppr | output | 8 | Processor priority |
| eoi_valid | output | 1 | A vector was retired last cycle |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector's trigger mode |

## Verification
The bench builds the block with its default word width of 32, which gives eight bitmap words. With that width it reaches vector 0x10 in the lowest word and 0xFF in the top word. It also reaches searches that cross word boundaries when several words hold vectors. The stimulus table reaches the strict-greater rule at an equal class. It also reaches in-service classes that override the threshold, a level vector accepted again as edge, and retirement combined with an accept in one cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_W   = 8;
  localparam int CLS_W   = 4;
  localparam int NUM_VEC = 1 << VEC_W;

  typedef logic [VEC_W-1:0] vec_t;

  // class of a vector with the sub-class bits zeroed
  function automatic vec_t class_of(vec_t v);
    return {v[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}};
  endfunction

  // processor priority from threshold and highest in-service vector
  function automatic vec_t proc_prio(vec_t thr, logic isr_any, vec_t isr_hi);
    vec_t iv;
    iv = isr_any ? isr_hi : '0;
    if (thr[VEC_W-1 -: CLS_W] >= iv[VEC_W-1 -: CLS_W]) return thr;
    return class_of(iv);
  endfunction

  function automatic logic may_deliver(logic irr_any, vec_t irr_hi, vec_t prio);
    return irr_any && (class_of(irr_hi) > prio);
  endfunction
endpackage

// File: rtl/irq_vec_search.sv
module irq_vec_search #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic [NUM_VEC-1:0]         map,
  output logic                       any,
  output logic [$clog2(NUM_VEC)-1:0] hi
);
  localparam int NWORD = NUM_VEC / WORD_W;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int IDX_W = $clog2(NUM_VEC);

  logic [NWORD-1:0]            w_any;
  logic [NWORD-1:0][BIT_W-1:0] w_msb;

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    logic [WORD_W-1:0] wd;
    logic [BIT_W-1:0]  msb;
    assign wd       = map[g*WORD_W +: WORD_W];
    assign w_any[g] = |wd;
    always_comb begin
      msb = '0;
      for (int b = 0; b < WORD_W; b++)
        if (wd[b]) msb = BIT_W'(b);
    end
    assign w_msb[g] = msb;
  end

  // upper words win: later iterations overwrite lower ones
  always_comb begin
    any = |w_any;
    hi  = '0;
    for (int w = 0; w < NWORD; w++)
      if (w_any[w]) hi = (IDX_W'(w) << BIT_W) | IDX_W'(w_msb[w]);
  end
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
  import irq_prio_pkg::*;
(
  input  vec_t thr,
  input  logic isr_any,
  input  vec_t isr_hi,
  input  logic irr_any,
  input  vec_t irr_hi,
  output vec_t ppr,
  output logic deliver
);
  assign ppr     = proc_prio(thr, isr_any, isr_hi);
  assign deliver = may_deliver(irr_any, irr_hi, ppr);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_en,
  input  logic        sw_en,
  input  logic        acc_valid,
  input  logic [7:0]  acc_vec,
  input  logic        acc_level,
  output logic        acc_new,
  input  logic        thr_wr,
  input  logic [31:0] thr_wdata,
  output logic [3:0]  thr_class,
  input  logic        ack,
  input  logic        eoi,
  output logic        dlv_valid,
  output logic [7:0]  dlv_vec,
  output logic [7:0]  ppr,
  output logic        eoi_valid,
  output logic [7:0]  eoi_vec,
  output logic        eoi_level
);
  localparam int NV = NUM_VEC;

  logic [NV-1:0] irr_q, isr_q, tmr_q;
  vec_t          thr_q;
  logic          irr_any, isr_any;
  vec_t          irr_hi, isr_hi;
  logic [23:0]   unused_thr_hi;

  assign unused_thr_hi = thr_wdata[31:8];

  irq_vec_search #(.NUM_VEC(NV), .WORD_W(WORD_W)) u_irr_search (
    .map(irr_q), .any(irr_any), .hi(irr_hi));
  irq_vec_search #(.NUM_VEC(NV), .WORD_W(WORD_W)) u_isr_search (
    .map(isr_q), .any(isr_any), .hi(isr_hi));

  irq_prio_gate u_gate (
    .thr(thr_q), .isr_any(isr_any), .isr_hi(isr_hi),
    .irr_any(irr_any), .irr_hi(irr_hi), .ppr(ppr), .deliver(dlv_valid));

  assign dlv_vec   = irr_hi;
  assign thr_class = thr_q[7:4];

  // named events
  logic          en, ack_fire, eoi_fire, acc_fire;
  logic [NV-1:0] ack_m, eoi_m, acc_m;
  logic [NV-1:0] irr_mid, tmr_mid;
  logic          acc_pend, acc_take;

  assign en       = hw_en & sw_en;
  assign ack_fire = ack & dlv_valid;
  assign eoi_fire = eoi & isr_any;
  assign acc_fire = acc_valid & en;
  assign ack_m    = ack_fire ? (NV'(1) << irr_hi) : '0;
  assign eoi_m    = eoi_fire ? (NV'(1) << isr_hi) : '0;
  assign acc_m    = NV'(1) << acc_vec;

  assign irr_mid  = irr_q & ~ack_m;
  assign tmr_mid  = tmr_q & ~eoi_m;
  assign acc_pend = irr_mid[acc_vec];
  assign acc_take = acc_fire & ~(acc_pend & acc_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q     <= '0;
      isr_q     <= '0;
      tmr_q     <= '0;
      thr_q     <= '0;
      acc_new   <= 1'b0;
      eoi_valid <= 1'b0;
      eoi_vec   <= '0;
      eoi_level <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~eoi_m) | ack_m;
      irr_q <= acc_take ? (irr_mid | acc_m) : irr_mid;
      if (acc_take)
        tmr_q <= acc_level ? (tmr_mid | acc_m) : (tmr_mid & ~acc_m);
      else
        tmr_q <= tmr_mid;
      if (thr_wr) thr_q <= thr_wdata[7:0];
      acc_new   <= acc_take & ~acc_pend;
      eoi_valid <= eoi_fire;
      eoi_vec   <= isr_hi;
      eoi_level <= tmr_q[isr_hi];
    end
  end

  // offered vector must outrank the processor priority
  p_deliver_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> ({dlv_vec[7:4], 4'h0} > ppr));

  // priority never drops below the threshold class
  p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ppr[7:4] >= thr_q[7:4]);

  p_ack_sets_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_q[$past(irr_hi)]);

  p_eoi_needs_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(isr_any));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_new |-> $past(en));

  p_level_dup_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_level && irr_q[acc_vec] && !ack_fire && !eoi_fire)
      |=> (!acc_new && irr_q[$past(acc_vec)]));

  p_legal_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_vec >= 8'd16));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] OP_NOP = 3'd0, OP_ACC = 3'd1, OP_THR = 3'd2,
                         OP_ACK = 3'd3, OP_EOI = 3'd4, OP_ACE = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic       lvl;
    logic       x_dv;
    logic [7:0] x_vec;
    logic [7:0] x_ppr;
    logic       x_ev;
    logic [7:0] x_evec;
    logic       x_elvl;
    logic       x_new;
  } step_t;

  localparam int NSTEP = 21;
  localparam step_t TBL [NSTEP] = '{
    '{OP_ACC, 8'h31, 1'b0, 1'b1, 8'h31, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1},
    '{OP_ACC, 8'h85, 1'b1, 1'b1, 8'h85, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1},
    '{OP_ACC, 8'h85, 1'b1, 1'b1, 8'h85, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_ACC, 8'h31, 1'b0, 1'b1, 8'h85, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h31, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_ACC, 8'h8A, 1'b0, 1'b0, 8'h8A, 8'h80, 1'b0, 8'h00, 1'b0, 1'b1},
    '{OP_ACC, 8'h92, 1'b0, 1'b1, 8'h92, 8'h80, 1'b0, 8'h00, 1'b0, 1'b1},
    '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h8A, 8'h90, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_EOI, 8'h00, 1'b0, 1'b0, 8'h8A, 8'h80, 1'b1, 8'h92, 1'b0, 1'b0},
    '{OP_EOI, 8'h00, 1'b0, 1'b1, 8'h8A, 8'h00, 1'b1, 8'h85, 1'b1, 1'b0},
    '{OP_EOI, 8'h00, 1'b0, 1'b1, 8'h8A, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_THR, 8'h87, 1'b0, 1'b0, 8'h8A, 8'h87, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_THR, 8'h70, 1'b0, 1'b1, 8'h8A, 8'h70, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h31, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_THR, 8'h95, 1'b0, 1'b0, 8'h31, 8'h95, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_THR, 8'h00, 1'b0, 1'b0, 8'h31, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_ACE, 8'hC4, 1'b1, 1'b1, 8'hC4, 8'h00, 1'b1, 8'h8A, 1'b0, 1'b1},
    '{OP_ACC, 8'hC4, 1'b0, 1'b1, 8'hC4, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h31, 8'hC0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_EOI, 8'h00, 1'b0, 1'b1, 8'h31, 8'h00, 1'b1, 8'hC4, 1'b0, 1'b0},
    '{OP_NOP, 8'h00, 1'b0, 1'b1, 8'h31, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hw_en = 1'b1, sw_en = 1'b1;
  logic        acc_valid = 1'b0, acc_level = 1'b0, thr_wr = 1'b0;
  logic [7:0]  acc_vec = '0;
  logic [31:0] thr_wdata = '0;
  logic        ack = 1'b0, eoi = 1'b0;
  logic        acc_new, dlv_valid, eoi_valid, eoi_level;
  logic [3:0]  thr_class;
  logic [7:0]  dlv_vec, ppr, eoi_vec;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
    .acc_new(acc_new), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .thr_class(thr_class), .ack(ack), .eoi(eoi), .dlv_valid(dlv_valid),
    .dlv_vec(dlv_vec), .ppr(ppr), .eoi_valid(eoi_valid),
    .eoi_vec(eoi_vec), .eoi_level(eoi_level));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation for one clock, return at the following falling edge
  task automatic drive(input logic [2:0] op, input logic [7:0] arg, input logic lvl);
    @(negedge clk);
    acc_valid = (op == OP_ACC) || (op == OP_ACE);
    acc_vec   = arg;
    acc_level = lvl;
    thr_wr    = (op == OP_THR);
    thr_wdata = {24'hA5C35A, arg};
    ack       = (op == OP_ACK);
    eoi       = (op == OP_EOI) || (op == OP_ACE);
    @(negedge clk);
    acc_valid = 1'b0; thr_wr = 1'b0; ack = 1'b0; eoi = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 dlv_valid", 8'(dlv_valid), 8'h0);
    chk("R11 dlv_vec", dlv_vec, 8'h00);
    chk("R11 ppr", ppr, 8'h00);
    chk("R11 eoi_valid", 8'(eoi_valid), 8'h0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10 R12
    for (int i = 0; i < NSTEP; i++) begin
      drive(TBL[i].op, TBL[i].arg, TBL[i].lvl);
      chk($sformatf("R3 step%0d dlv_valid", i), 8'(dlv_valid), 8'(TBL[i].x_dv));
      chk($sformatf("R1 step%0d dlv_vec", i), dlv_vec, TBL[i].x_vec);
      chk($sformatf("R2 step%0d ppr", i), ppr, TBL[i].x_ppr);
      chk($sformatf("R5 step%0d eoi_valid", i), 8'(eoi_valid), 8'(TBL[i].x_ev));
      if (TBL[i].x_ev) begin
        chk($sformatf("R5 step%0d eoi_vec", i), eoi_vec, TBL[i].x_evec);
        chk($sformatf("R5 step%0d eoi_level", i), 8'(eoi_level), 8'(TBL[i].x_elvl));
      end
      chk($sformatf("R8 step%0d acc_new", i), 8'(acc_new), 8'(TBL[i].x_new));
    end

    // R10 threshold keeps low byte, class view
    drive(OP_THR, 8'hB3, 1'b0);
    chk("R10 thr_class", 8'(thr_class), 8'h0B);
    chk("R10 ppr low byte", ppr, 8'hB3);
    drive(OP_THR, 8'h00, 1'b0);

    // R9 accepts ignored while disabled
    sw_en = 1'b0;
    drive(OP_ACC, 8'hE0, 1'b0);
    chk("R9 sw off acc_new", 8'(acc_new), 8'h0);
    chk("R9 sw off dlv_vec", dlv_vec, 8'h31);
    sw_en = 1'b1; hw_en = 1'b0;
    drive(OP_ACC, 8'hE0, 1'b0);
    chk("R9 hw off acc_new", 8'(acc_new), 8'h0);
    chk("R9 hw off dlv_vec", dlv_vec, 8'h31);
    hw_en = 1'b1;

    // R11 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 reset dlv_valid", 8'(dlv_valid), 8'h0);
    chk("R11 reset dlv_vec", dlv_vec, 8'h00);
    chk("R11 reset thr_class", 8'(thr_class), 8'h0);

    // R1 word boundaries: lowest legal and top vector
    drive(OP_ACC, 8'h10, 1'b0);
    chk("R1 vec 0x10", dlv_vec, 8'h10);
    chk("R3 vec 0x10 valid", 8'(dlv_valid), 8'h1);
    drive(OP_ACC, 8'hFF, 1'b0);
    chk("R1 vec 0xFF", dlv_vec, 8'hFF);
    drive(OP_ACK, 8'h00, 1'b0);
    chk("R2 ppr after FF", ppr, 8'hF0);
    chk("R3 0x10 blocked", 8'(dlv_valid), 8'h0);
    drive(OP_EOI, 8'h00, 1'b0);
    chk("R5 retire FF", eoi_vec, 8'hFF);
    chk("R5 FF edge", 8'(eoi_level), 8'h0);
    chk("R3 0x10 open", 8'(dlv_valid), 8'h1);

    // R12 accept and retire of the same vector in one cycle
    drive(OP_ACK, 8'h00, 1'b0);
    chk("R4 ppr 0x10", ppr, 8'h10);
    drive(OP_ACE, 8'h10, 1'b1);
    chk("R12 retire 0x10", eoi_vec, 8'h10);
    chk("R12 retire edge", 8'(eoi_level), 8'h0);
    chk("R12 new pending", 8'(acc_new), 8'h1);
    drive(OP_ACK, 8'h00, 1'b0);
    drive(OP_EOI, 8'h00, 1'b0);
    chk("R12 level kept", 8'(eoi_level), 8'h1);
    chk("R4 ack with nothing deliverable", 8'(dlv_valid), 8'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule